// File: doc/BRIEF.md
# Video Raster Timing, Test Pattern and Composite Sync Generator

This block produces a complete raster: horizontal sync, vertical sync, data-enable and a composite sync, plus a 24-bit RGB pixel stream. The internal timing comes from two programmable counters, one counting pixels and one counting lines. Each counter is set by a period, the length of its sync pulse, the distance from the start of sync to the first active position, and the number of active positions. A select input decides whether this internal timing or the external sync inputs (HS, VS, DE) drive the outputs and the pattern position.

The pixel path either forwards the incoming pixel word unchanged or replaces it with one of a fixed menu of synthetic patterns. These are flat black and white, grey ramps along either axis, eight wide colour bars, colour bars one pixel wide, and a zigzag ramp. The composite sync is formed from the active-high HS and VS by a selectable XOR, OR or AND rule. Separate invert bits set the polarity of the HS and VS outputs.

The video path has no back-pressure. It accepts one pixel and emits one pixel on every clock, so it carries no valid/ready handshake: DE is the only qualifier. Configuration inputs are plain levels and should be held steady while a frame runs. External sync inputs are taken as active high.

Top module: `vtg_top`

## Requirements
- R1: In internal mode the pixel counter runs from 0 to `cfg_h_total`-1 and wraps. HS is active while the count is below `cfg_h_sync_w`. A pixel is horizontally active while the count is at least `cfg_h_offset` and below `cfg_h_offset`+`cfg_h_active`.
- R2: The line counter advances once, on the last pixel of each line. It runs from 0 to `cfg_v_total`-1, with VS and vertical activity decoded from the `cfg_v_*` inputs by the same rules as R1. DE is high only where both axes are active.
- R3: Every output is registered and shows the timing position of the previous clock. While `rst_n` is low all outputs are 0. After release, the first output cycle shows position (0,0).
- R4: `out_hs` equals the active-high HS XOR `cfg_h_pol_inv`, and `out_vs` equals the active-high VS XOR `cfg_v_pol_inv`.
- R5: With `cfg_use_ext_sync`=1, `out_hs`, `out_vs` and `out_de` follow `in_hs`, `in_vs` and `in_de` one clock later (subject to R4), and pattern positions are counted from those inputs.
- R6: With `cfg_test_en`=0 and DE high, `out_pixel` equals the `in_pixel` of the previous clock.
- R7: `out_pixel` is 0 whenever `out_de` is 0, in every mode.
- R8: Pattern code 0 gives 24'h000000 and code 1 gives 24'hFFFFFF. Codes 7 to 15 give black.
- R9: The pixel word is R in [23:16], G in [15:8] and B in [7:0]. A grey level g appears as {g,g,g}. Code 3 (horizontal ramp) shows g = x mod 256, where x counts active pixels since DE rose. Code 2 (vertical ramp) shows g = y mod 256, where y counts active lines since the last VS.
- R10: Code 4 splits the line into 8 bars of width `cfg_h_active`/8 (truncated, at least 1), and bar 7 takes all remaining pixels. Bar colours 0..7 are FFFFFF, FFFF00, 00FFFF, 00FF00, FF00FF, FF0000, 0000FF, 000000.
- R11: Code 5 shows the colour of bar index x mod 8, using the colours of R10.
- R12: Code 6 (zigzag) shows g = x mod 256 when bit 8 of x is 0, and 255 - (x mod 256) when it is 1.
- R13: `out_csync` combines the active-high HS and VS, before any inversion. `cfg_csync_sel` 0 gives XOR, 1 gives OR and 2 gives AND; codes 3 to 7 behave as XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_total | input | CW | Clocks per line |
| cfg_h_active | input | CW | Active pixels per line |
| cfg_h_offset | input | CW | Sync start to first active pixel, in clocks |
| cfg_h_sync_w | input | CW | HS pulse width in clocks |
| cfg_v_total | input | CW | Lines per frame |
| cfg_v_active | input | CW | Active lines per frame |
| cfg_v_offset | input | CW | Sync start to first active line, in lines |
| cfg_v_sync_w | input | CW | VS pulse width in lines |
| cfg_h_pol_inv | input | 1 | Invert HS output |
| cfg_v_pol_inv | input | 1 | Invert VS output |
| cfg_test_en | input | 1 | Replace input pixels with the pattern |
| cfg_pattern | input | 4 | Pattern code |
| cfg_use_ext_sync | input | 1 | 1: external sync drives outputs and positions |
| cfg_csync_sel | input | 3 | Composite sync rule |
| in_hs | input | 1 | External HS, active high |
| in_vs | input | 1 | External VS, active high |
| in_de | input | 1 | External data-enable |
| in_pixel | input | 3*CH_W | Incoming RGB pixel |
| out_hs | output | 1 | HS output |
| out_vs | output | 1 | VS output |
| out_de | output | 1 | DE output |
| out_csync | output | 1 | Composite sync output |
| out_pixel | output | 3*CH_W | RGB pixel output |

## Verification
A wrong pixel or line count appears on the next clock as HS, VS or DE at the wrong position, and it stays shifted for the rest of the frame. The bench therefore compares every cycle of two full internal frames against positions computed from the settings. A stale horizontal position or bar counter shows first as a wrong colour or grey level at a chosen pixel. A position that fails to reset shows on the first active pixel after DE rises. A vertical position error can show only after the first completed active line, so the ramp checks reach several lines into a frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam logic [3:0] PAT_BLACK   = 4'd0;
  localparam logic [3:0] PAT_WHITE   = 4'd1;
  localparam logic [3:0] PAT_VRAMP   = 4'd2;
  localparam logic [3:0] PAT_HRAMP   = 4'd3;
  localparam logic [3:0] PAT_BARS    = 4'd4;
  localparam logic [3:0] PAT_PIXBARS = 4'd5;
  localparam logic [3:0] PAT_ZIGZAG  = 4'd6;

  localparam logic [2:0] CS_XOR = 3'd0;
  localparam logic [2:0] CS_OR  = 3'd1;
  localparam logic [2:0] CS_AND = 3'd2;

  localparam int AXIS_H = 0;
  localparam int AXIS_V = 1;
  localparam int N_AXES = 2;
  localparam int N_BARS = 8;
  localparam int BAR_IW = $clog2(N_BARS);

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } vtiming_t;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] active,
  input  logic [CW-1:0] offset,
  input  logic [CW-1:0] sync_w,
  output logic          wrap,
  output logic          sync,
  output logic          act
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_x, nxt, off_x, end_x;
  logic          last;

  assign cnt_x = {1'b0, cnt};
  assign nxt   = cnt_x + 1'b1;
  assign off_x = {1'b0, offset};
  assign end_x = off_x + {1'b0, active};
  assign last  = (nxt >= {1'b0, total});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= last ? '0 : nxt[CW-1:0];
  end

  assign wrap = adv & last;
  assign sync = (cnt < sync_w);
  assign act  = (cnt_x >= off_x) && (cnt_x < end_x);
endmodule

// File: rtl/vtg_timing.sv
module vtg_timing
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_AXES-1:0][CW-1:0]    total,
  input  logic [N_AXES-1:0][CW-1:0]    active,
  input  logic [N_AXES-1:0][CW-1:0]    offset,
  input  logic [N_AXES-1:0][CW-1:0]    sync_w,
  output vtiming_t                     tm
);
  logic [N_AXES-1:0] adv, wrap, sync, act;
  logic unused_frame_end;

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    if (a == 0) begin : g_first
      assign adv[a] = 1'b1;
    end else begin : g_chain
      assign adv[a] = wrap[a-1];
    end
    vtg_axis #(.CW(CW)) u_axis (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv[a]),
      .total  (total[a]),
      .active (active[a]),
      .offset (offset[a]),
      .sync_w (sync_w[a]),
      .wrap   (wrap[a]),
      .sync   (sync[a]),
      .act    (act[a])
    );
  end

  assign unused_frame_end = wrap[N_AXES-1];
  assign tm.hs = sync[AXIS_H];
  assign tm.vs = sync[AXIS_V];
  assign tm.de = &act;
endmodule

// File: rtl/vtg_tracker.sv
module vtg_tracker
  import vtg_pkg::*;
#(
  parameter int CW   = 12,
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vtiming_t          tm,
  input  logic [CW-1:0]     h_active,
  output logic [CH_W:0]     x,
  output logic [CH_W-1:0]   y,
  output logic [BAR_IW-1:0] bar
);
  localparam logic [BAR_IW-1:0] BAR_LAST = BAR_IW'(N_BARS - 1);

  logic          de_q;
  logic [CW-1:0] bar_pos, bw_raw, bar_w;

  assign bw_raw = h_active >> BAR_IW;
  assign bar_w  = (bw_raw == '0) ? CW'(1) : bw_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q    <= 1'b0;
      x       <= '0;
      y       <= '0;
      bar     <= '0;
      bar_pos <= '0;
    end else begin
      de_q <= tm.de;
      if (tm.de) x <= x + 1'b1;
      else       x <= '0;
      if (tm.vs)                y <= '0;
      else if (de_q && !tm.de)  y <= y + 1'b1;
      if (!tm.de) begin
        bar     <= '0;
        bar_pos <= '0;
      end else if (bar != BAR_LAST) begin
        if (bar_pos == bar_w - 1'b1) begin
          bar_pos <= '0;
          bar     <= bar + 1'b1;
        end else begin
          bar_pos <= bar_pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vtg_pattern.sv
module vtg_pattern
  import vtg_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic [3:0]        code,
  input  logic [CH_W:0]     x,
  input  logic [CH_W-1:0]   y,
  input  logic [BAR_IW-1:0] bar,
  output logic [3*CH_W-1:0] pix
);
  function automatic logic [3*CH_W-1:0] colour(input logic [BAR_IW-1:0] idx);
    logic [2:0] rgb;
    case (idx)
      3'd0:    rgb = 3'b111;
      3'd1:    rgb = 3'b110;
      3'd2:    rgb = 3'b011;
      3'd3:    rgb = 3'b010;
      3'd4:    rgb = 3'b101;
      3'd5:    rgb = 3'b100;
      3'd6:    rgb = 3'b001;
      default: rgb = 3'b000;
    endcase
    return {{CH_W{rgb[2]}}, {CH_W{rgb[1]}}, {CH_W{rgb[0]}}};
  endfunction

  function automatic logic [3*CH_W-1:0] grey(input logic [CH_W-1:0] g);
    return {g, g, g};
  endfunction

  logic [CH_W-1:0] zig;
  assign zig = x[CH_W] ? ~x[CH_W-1:0] : x[CH_W-1:0];

  always_comb begin
    case (code)
      PAT_WHITE:   pix = '1;
      PAT_VRAMP:   pix = grey(y);
      PAT_HRAMP:   pix = grey(x[CH_W-1:0]);
      PAT_BARS:    pix = colour(bar);
      PAT_PIXBARS: pix = colour(x[BAR_IW-1:0]);
      PAT_ZIGZAG:  pix = grey(zig);
      default:     pix = '0;
    endcase
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CW   = 12,
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cfg_h_total,
  input  logic [CW-1:0]     cfg_h_active,
  input  logic [CW-1:0]     cfg_h_offset,
  input  logic [CW-1:0]     cfg_h_sync_w,
  input  logic [CW-1:0]     cfg_v_total,
  input  logic [CW-1:0]     cfg_v_active,
  input  logic [CW-1:0]     cfg_v_offset,
  input  logic [CW-1:0]     cfg_v_sync_w,
  input  logic              cfg_h_pol_inv,
  input  logic              cfg_v_pol_inv,
  input  logic              cfg_test_en,
  input  logic [3:0]        cfg_pattern,
  input  logic              cfg_use_ext_sync,
  input  logic [2:0]        cfg_csync_sel,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_de,
  input  logic [3*CH_W-1:0] in_pixel,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_de,
  output logic              out_csync,
  output logic [3*CH_W-1:0] out_pixel
);
  localparam int PIX_W = 3 * CH_W;

  logic [N_AXES-1:0][CW-1:0] tot_a, act_a, off_a, sw_a;
  vtiming_t int_tm, ext_tm, sel_tm;
  logic [CH_W:0]     pos_x;
  logic [CH_W-1:0]   pos_y;
  logic [BAR_IW-1:0] bar_idx;
  logic [PIX_W-1:0]  pat_pix;
  logic              csync_d;

  assign tot_a = {cfg_v_total,  cfg_h_total};
  assign act_a = {cfg_v_active, cfg_h_active};
  assign off_a = {cfg_v_offset, cfg_h_offset};
  assign sw_a  = {cfg_v_sync_w, cfg_h_sync_w};

  vtg_timing #(.CW(CW)) u_timing (
    .clk    (clk),
    .rst_n  (rst_n),
    .total  (tot_a),
    .active (act_a),
    .offset (off_a),
    .sync_w (sw_a),
    .tm     (int_tm)
  );

  assign ext_tm.hs = in_hs;
  assign ext_tm.vs = in_vs;
  assign ext_tm.de = in_de;
  assign sel_tm    = cfg_use_ext_sync ? ext_tm : int_tm;

  vtg_tracker #(.CW(CW), .CH_W(CH_W)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .tm       (sel_tm),
    .h_active (cfg_h_active),
    .x        (pos_x),
    .y        (pos_y),
    .bar      (bar_idx)
  );

  vtg_pattern #(.CH_W(CH_W)) u_pattern (
    .code (cfg_pattern),
    .x    (pos_x),
    .y    (pos_y),
    .bar  (bar_idx),
    .pix  (pat_pix)
  );

  always_comb begin
    case (cfg_csync_sel)
      CS_OR:   csync_d = sel_tm.hs | sel_tm.vs;
      CS_AND:  csync_d = sel_tm.hs & sel_tm.vs;
      default: csync_d = sel_tm.hs ^ sel_tm.vs;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hs    <= 1'b0;
      out_vs    <= 1'b0;
      out_de    <= 1'b0;
      out_csync <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_hs    <= sel_tm.hs ^ cfg_h_pol_inv;
      out_vs    <= sel_tm.vs ^ cfg_v_pol_inv;
      out_de    <= sel_tm.de;
      out_csync <= csync_d;
      if (!sel_tm.de)      out_pixel <= '0;
      else if (cfg_test_en) out_pixel <= pat_pix;
      else                 out_pixel <= in_pixel;
    end
  end
endmodule

// File: rtl/vtg_top_chk.sv
module vtg_top_chk #(
  parameter int CH_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_h_pol_inv,
  input logic              cfg_v_pol_inv,
  input logic              cfg_test_en,
  input logic [3:0]        cfg_pattern,
  input logic              cfg_use_ext_sync,
  input logic [2:0]        cfg_csync_sel,
  input logic              in_hs,
  input logic              in_de,
  input logic [3*CH_W-1:0] in_pixel,
  input logic              out_hs,
  input logic              out_vs,
  input logic              out_de,
  input logic              out_csync,
  input logic [3*CH_W-1:0] out_pixel
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_pixel == '0));

  p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_use_ext_sync && in_de && !cfg_test_en))
      |-> (out_pixel == $past(in_pixel)));

  p_ext_de_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_use_ext_sync)) |-> (out_de == $past(in_de)));

  p_ext_hs_pol_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_use_ext_sync))
      |-> (out_hs == ($past(in_hs) ^ $past(cfg_h_pol_inv))));

  p_csync_and_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_csync_sel == 3'd2 && !cfg_h_pol_inv && !cfg_v_pol_inv))
      |-> (out_csync == (out_hs & out_vs)));

  p_white_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(cfg_test_en && cfg_pattern == 4'd1) && out_de)
      |-> (out_pixel == '1));
endmodule

bind vtg_top vtg_top_chk #(.CH_W(CH_W)) u_chk (.*);

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb;
  localparam int CW = 12;
  localparam int CH_W = 8;
  localparam int LINE_LEN = 300;
  localparam int HT = 20, HA = 8, HO = 5, HS = 3;
  localparam int VT = 6, VA = 3, VO = 2, VS = 1;
  localparam int NV = 20;

  // {req[3:0], test_en, pattern[3:0], line y[7:0], pixel x[11:0], expected[23:0]}
  localparam logic [52:0] VEC [NV] = '{
    {4'd8,  1'b1, 4'd1, 8'd0, 12'd5,   24'hFFFFFF}, // R8 white
    {4'd8,  1'b1, 4'd0, 8'd0, 12'd10,  24'h000000}, // R8 black
    {4'd8,  1'b1, 4'd9, 8'd0, 12'd3,   24'h000000}, // R8 unused code
    {4'd9,  1'b1, 4'd3, 8'd0, 12'd37,  24'h252525}, // R9 h ramp
    {4'd9,  1'b1, 4'd3, 8'd0, 12'd260, 24'h040404}, // R9 h ramp wraps
    {4'd9,  1'b1, 4'd2, 8'd5, 12'd7,   24'h050505}, // R9 v ramp
    {4'd10, 1'b1, 4'd4, 8'd0, 12'd0,   24'hFFFFFF}, // R10 bar 0
    {4'd10, 1'b1, 4'd4, 8'd0, 12'd12,  24'hFFFF00}, // R10 bar 1
    {4'd10, 1'b1, 4'd4, 8'd0, 12'd35,  24'h00FFFF}, // R10 bar 2
    {4'd10, 1'b1, 4'd4, 8'd0, 12'd60,  24'hFF0000}, // R10 bar 5
    {4'd10, 1'b1, 4'd4, 8'd0, 12'd83,  24'h0000FF}, // R10 bar 6 end
    {4'd10, 1'b1, 4'd4, 8'd0, 12'd95,  24'h000000}, // R10 last bar absorbs
    {4'd11, 1'b1, 4'd5, 8'd0, 12'd3,   24'h00FF00}, // R11
    {4'd11, 1'b1, 4'd5, 8'd0, 12'd13,  24'hFF0000}, // R11
    {4'd11, 1'b1, 4'd5, 8'd0, 12'd14,  24'h0000FF}, // R11
    {4'd12, 1'b1, 4'd6, 8'd0, 12'd10,  24'h0A0A0A}, // R12 rising
    {4'd12, 1'b1, 4'd6, 8'd0, 12'd255, 24'hFFFFFF}, // R12 top
    {4'd12, 1'b1, 4'd6, 8'd0, 12'd256, 24'hFFFFFF}, // R12 turn
    {4'd12, 1'b1, 4'd6, 8'd0, 12'd260, 24'hFBFBFB}, // R12 falling
    {4'd6,  1'b0, 4'd1, 8'd0, 12'd20,  24'h123414}  // R6 pass-through
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cfg_h_total, cfg_h_active, cfg_h_offset, cfg_h_sync_w;
  logic [CW-1:0] cfg_v_total, cfg_v_active, cfg_v_offset, cfg_v_sync_w;
  logic cfg_h_pol_inv, cfg_v_pol_inv, cfg_test_en, cfg_use_ext_sync;
  logic [3:0] cfg_pattern;
  logic [2:0] cfg_csync_sel;
  logic in_hs, in_vs, in_de;
  logic [3*CH_W-1:0] in_pixel;
  logic out_hs, out_vs, out_de, out_csync;
  logic [3*CH_W-1:0] out_pixel;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vtg_top #(.CW(CW), .CH_W(CH_W)) u_dut (.*);

  task automatic check(input logic [23:0] act, input logic [23:0] exp,
                       input string req, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({20'd0, out_hs, out_vs, out_de, out_csync}, 24'd0, "R3", "sync outputs in reset");
    check(out_pixel, 24'd0, "R3", "pixel in reset");
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input logic en, input logic [3:0] pat, input int y,
                         input int x, input logic [23:0] exp, input string req);
    cfg_test_en = en;
    cfg_pattern = pat;
    @(negedge clk);
    in_vs = 1'b1; in_de = 1'b0;
    @(negedge clk);
    in_vs = 1'b0;
    for (int ln = 0; ln <= y; ln++) begin
      for (int i = 0; i <= LINE_LEN; i++) begin
        @(negedge clk);
        if (ln == y && i > 0 && i - 1 == x) check(out_pixel, exp, req, "pattern pixel");
        in_de = (i < LINE_LEN);
        in_pixel = 24'h123400 + 24'(i);
      end
      repeat (3) @(negedge clk);
    end
  endtask

  // Internal timing walk over two frames: R1 R2 R3 R4 R13 and pixels R9 R7
  task automatic walk(input logic [3:0] pat, input logic [2:0] csel,
                      input logic hinv, input logic vinv);
    cfg_use_ext_sync = 1'b0;
    cfg_test_en = 1'b1;
    cfg_pattern = pat;
    cfg_csync_sel = csel;
    cfg_h_pol_inv = hinv;
    cfg_v_pol_inv = vinv;
    cfg_h_total = CW'(HT); cfg_h_active = CW'(HA); cfg_h_offset = CW'(HO); cfg_h_sync_w = CW'(HS);
    cfg_v_total = CW'(VT); cfg_v_active = CW'(VA); cfg_v_offset = CW'(VO); cfg_v_sync_w = CW'(VS);
    do_reset();
    for (int k = 0; k < 2 * HT * VT; k++) begin
      int h, v;
      logic hs_a, vs_a, de_e, cs_e;
      logic [7:0] g;
      @(negedge clk);
      h = k % HT;
      v = (k / HT) % VT;
      hs_a = (h < HS);
      vs_a = (v < VS);
      de_e = (h >= HO) && (h < HO + HA) && (v >= VO) && (v < VO + VA);
      case (csel)
        3'd1:    cs_e = hs_a | vs_a;
        3'd2:    cs_e = hs_a & vs_a;
        default: cs_e = hs_a ^ vs_a;
      endcase
      g = (pat == 4'd3) ? 8'(h - HO) : 8'(v - VO);
      check({23'd0, out_hs}, {23'd0, hs_a ^ hinv}, "R1", "hsync (R4 polarity)");
      check({23'd0, out_vs}, {23'd0, vs_a ^ vinv}, "R2", "vsync (R4 polarity)");
      check({23'd0, out_de}, {23'd0, de_e}, "R2", "data enable");
      check({23'd0, out_csync}, {23'd0, cs_e}, "R13", "composite sync");
      check(out_pixel, de_e ? {g, g, g} : 24'd0, "R9", "internal ramp / R7 blank");
    end
  endtask

  initial begin
    cfg_h_pol_inv = 0; cfg_v_pol_inv = 0; cfg_test_en = 0; cfg_pattern = 0;
    cfg_use_ext_sync = 1; cfg_csync_sel = 0;
    cfg_h_total = 0; cfg_h_active = 0; cfg_h_offset = 0; cfg_h_sync_w = 0;
    cfg_v_total = 0; cfg_v_active = 0; cfg_v_offset = 0; cfg_v_sync_w = 0;
    in_hs = 0; in_vs = 0; in_de = 0; in_pixel = '0;

    walk(4'd3, 3'd0, 1'b0, 1'b0);
    walk(4'd2, 3'd1, 1'b1, 1'b1);
    walk(4'd3, 3'd2, 1'b0, 1'b0);
    walk(4'd2, 3'd5, 1'b1, 1'b0);

    // External-sync vector table: R6 R8 R9 R10 R11 R12
    cfg_use_ext_sync = 1'b1;
    cfg_h_pol_inv = 1'b0; cfg_v_pol_inv = 1'b0; cfg_csync_sel = 3'd0;
    cfg_h_active = CW'(100);
    do_reset();
    for (int k = 0; k < NV; k++)
      run_vec(VEC[k][48], VEC[k][47:44], int'(VEC[k][43:36]), int'(VEC[k][35:24]),
              VEC[k][23:0], $sformatf("R%0d", VEC[k][52:49]));

    // R5 external sync follow with R4 inversion and R13 XOR
    cfg_h_pol_inv = 1'b1;
    @(negedge clk);
    in_hs = 1; in_vs = 1; in_de = 0;
    @(negedge clk);
    check({21'd0, out_hs, out_vs, out_de}, 24'b010, "R5", "ext sync follow, inverted hs");
    check({23'd0, out_csync}, 24'd0, "R13", "csync xor of 1,1");
    in_hs = 0; in_vs = 1; in_de = 1;
    @(negedge clk);
    check({21'd0, out_hs, out_vs, out_de}, 24'b111, "R5", "ext sync follow second");
    check({23'd0, out_csync}, 24'd1, "R13", "csync xor of 0,1");
    cfg_h_pol_inv = 1'b0;

    // R7 blank forces zero in pattern and pass-through modes
    cfg_test_en = 1; cfg_pattern = 4'd1; in_de = 0; in_vs = 0; in_pixel = 24'hFFFFFF;
    @(negedge clk);
    @(negedge clk);
    check(out_pixel, 24'd0, "R7", "blank in pattern mode");
    cfg_test_en = 0;
    @(negedge clk);
    @(negedge clk);
    check(out_pixel, 24'd0, "R7", "blank in pass-through mode");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule